// File: doc/BRIEF.md
# Sequential Restoring Divider with Fractional Mode

This block divides one unsigned 16-bit operand by another, one quotient bit per clock, using a restoring shift-and-subtract loop. A single start strobe captures both operands and the mode bit, and it launches the operation. Completion is marked by a one-cycle done pulse. The quotient, remainder and overflow flag then stay steady until the next start.

The mode bit decides how the dividend is read. With the mode bit high, the dividend is an integer and the block returns the integer quotient and its remainder. With the mode bit low, the dividend is read as a binary fraction: it is extended below the binary point by sixteen zero bits, so the 32-bit numerator is dividend·2^16. The block returns the sixteen fraction bits of the quotient and the matching remainder.

Some results cannot be represented. These are a zero divisor in either mode, and a fractional division whose dividend is not below the divisor. In these cases the block skips the loop. It saturates the quotient to all ones, returns the dividend as the remainder, raises overflow and finishes on the very next cycle.

Top module: `seq_divider`

## Requirements
- R1: A cycle with `start` high captures `dividend`, `divisor` and `int_mode`. For a representable division, `busy` is high from the next cycle until the operation completes.
- R2: With `int_mode` = 1 and a nonzero divisor, the result is `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, so that quotient·divisor + remainder = dividend.
- R3: With `int_mode` = 0 and dividend < divisor, the result is `quotient` = floor(dividend·2^16 / divisor) and `remainder` = (dividend·2^16) mod divisor.
- R4: A representable division raises `done` for exactly one cycle, 17 clock edges after the edge that sampled `start`. `busy` falls on that same edge, and `busy` and `done` are never high together.
- R5: A zero divisor in either mode sets `overflow`, forces `quotient` to 0xFFFF and sets `remainder` to the dividend. `done` pulses on the edge right after the one that sampled `start`, and `busy` stays low.
- R6: With `int_mode` = 0 and a nonzero divisor that is not greater than the dividend, the block behaves as in R5.
- R7: A start for a representable division clears `overflow` on the edge that samples it.
- R8: A `start` while `busy` is high abandons the running division and begins the new one. The result and the timing are those of the new operands alone.
- R9: While no division is running and `start` is low, `quotient`, `remainder` and `overflow` hold their values whatever the operand inputs do.
- R10: After reset, `busy`, `done`, `overflow`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin; restarts a running division |
| int_mode | input | 1 | 1 = integer quotient and remainder, 0 = fractional quotient |
| dividend | input | 16 | Numerator (integer or fraction) |
| divisor | input | 16 | Denominator |
| busy | output | 1 | Division loop running |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient, or 0xFFFF on overflow |
| remainder | output | 16 | Remainder, or the dividend on overflow |
| overflow | output | 1 | Result not representable (includes zero divisor) |

## Verification
On every cycle the assertions check the handshake: `busy` and `done` are exclusive, `done` is a single pulse, and its latency from the last start is exact. They also check the saturated response to a zero divisor, the clearing of overflow on a good start, and that outputs hold while idle. The arithmetic itself can only be shown by the bench scenarios, because the checker keeps no copy of the operands. These scenarios compare integer and fractional results against independently computed quotients and remainders. They also cover the fractional overflow boundary at dividend equal to divisor, and a restart in the middle of a division.

// File: rtl/div_pkg.sv
package div_pkg;
   // mode encoding seen on the int_mode pin
   typedef enum logic {
      MODE_FRAC = 1'b0,
      MODE_INT  = 1'b1
   } div_mode_e;

   localparam int DIV_W_DEFAULT = 16;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl #(
   parameter int STEPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fast_finish,
   output logic busy,
   output logic done,
   output logic step_en
);
   localparam int CW = $clog2(STEPS + 1);
   localparam logic [CW-1:0] LAST  = CW'(1);
   localparam logic [CW-1:0] FIRST = CW'(STEPS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else if (start) begin
         cnt_q <= fast_finish ? '0 : FIRST;
         busy  <= !fast_finish;
         done  <= fast_finish;
      end else if (busy) begin
         cnt_q <= cnt_q - CW'(1);
         busy  <= (cnt_q != LAST);
         done  <= (cnt_q == LAST);
      end else begin
         done  <= 1'b0;
      end
   end

   assign step_en = busy && !start;
endmodule

// File: rtl/div_step.sv
module div_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] part_rem,
   input  logic         next_bit,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] part_rem_nxt,
   output logic         q_bit
);
   logic [W:0] shifted;
   logic [W:0] trial;

   always_comb begin
      shifted      = {part_rem, next_bit};
      trial        = shifted - {1'b0, dvs};
      q_bit        = (shifted >= {1'b0, dvs});
      part_rem_nxt = q_bit ? trial[W-1:0] : shifted[W-1:0];
   end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
   import div_pkg::*;
#(
   parameter int WIDTH = DIV_W_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             int_mode,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             overflow
);
   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("seq_divider: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
   logic             ovf_q;
   logic             zero_dvs, frac_big, fast;
   logic             step_en;
   logic [WIDTH-1:0] rem_nxt;
   logic             qb;
   div_mode_e        mode;

   assign mode     = div_mode_e'(int_mode);
   assign zero_dvs = (divisor == '0);
   assign frac_big = (mode == MODE_FRAC) && (dividend >= divisor);
   assign fast     = zero_dvs || frac_big;

   div_ctrl #(.STEPS(WIDTH)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .fast_finish (fast),
      .busy        (busy),
      .done        (done),
      .step_en     (step_en)
   );

   div_step #(.W(WIDTH)) step_i (
      .part_rem     (rem_q),
      .next_bit     (quo_q[WIDTH-1]),
      .dvs          (dvs_q),
      .part_rem_nxt (rem_nxt),
      .q_bit        (qb)
   );

   // quo_q holds numerator bits still to enter, then collects quotient bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         ovf_q <= 1'b0;
      end else if (start) begin
         dvs_q <= divisor;
         ovf_q <= fast;
         if (fast) begin
            rem_q <= dividend;
            quo_q <= '1;
         end else if (mode == MODE_INT) begin
            rem_q <= '0;
            quo_q <= dividend;
         end else begin
            rem_q <= dividend;
            quo_q <= '0;
         end
      end else if (step_en) begin
         rem_q <= rem_nxt;
         quo_q <= {quo_q[WIDTH-2:0], qb};
      end
   end

   assign quotient  = quo_q;
   assign remainder = rem_q;
   assign overflow  = ovf_q;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             int_mode,
   input logic [WIDTH-1:0] dividend,
   input logic [WIDTH-1:0] divisor,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder,
   input logic             overflow
);
   localparam int LW = $clog2(WIDTH + 4);
   logic [LW-1:0] lat_q;

   // edges seen since the last start, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lat_q <= '0;
      else if (start)               lat_q <= LW'(1);
      else if (busy && lat_q != '1) lat_q <= lat_q + LW'(1);
   end

   // R4
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);

   // R4
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !overflow |-> lat_q == LW'(WIDTH + 1));

   // R5
   zero_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && divisor == '0 |=> overflow && done && !busy && quotient == '1);

   // R1 R7
   good_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && int_mode && divisor != '0 |=> busy && !overflow && !done);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(quotient) && $stable(remainder) && $stable(overflow));
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .int_mode  (int_mode),
   .dividend  (dividend),
   .divisor   (divisor),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder),
   .overflow  (overflow)
);

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        int_mode = 1'b1;
   logic [15:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, overflow;
   logic [15:0] quotient, remainder;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   seq_divider dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .int_mode(int_mode),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder), .overflow(overflow)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // issue one division and verify result, flags and latency
   task automatic run_div(input logic [15:0] a, input logic [15:0] b, input logic m,
                          input string req);
      logic        ovf;
      logic [31:0] num;
      logic [15:0] eq, er;
      int          lat;
      ovf = (b == 0) || (!m && a >= b);
      num = m ? {16'h0, a} : {a, 16'h0};
      if (ovf) begin
         eq = 16'hFFFF;
         er = a;
      end else begin
         eq = 16'(num / {16'h0, b});
         er = 16'(num % {16'h0, b});
      end
      start = 1'b1; dividend = a; divisor = b; int_mode = m;
      lat = 0;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      if (!ovf) check({req, " R1 busy after start"}, 32'(busy), 32'd1);
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check({req, " R4 latency"}, 32'(lat), ovf ? 32'd1 : 32'd17);
      check({req, " quotient"}, 32'(quotient), 32'(eq));
      check({req, " remainder"}, 32'(remainder), 32'(er));
      check({req, " overflow"}, 32'(overflow), 32'(ovf));
      if (!ovf && m) check({req, " R2 q*b+r"}, 32'(quotient) * 32'(b) + 32'(remainder), 32'(a));
      @(negedge clk);
      check({req, " R4 single pulse"}, 32'(done), 32'd0);
   endtask

   task automatic t_reset();
      check("R10 busy", 32'(busy), 0);
      check("R10 done", 32'(done), 0);
      check("R10 overflow", 32'(overflow), 0);
      check("R10 quotient", 32'(quotient), 0);
      check("R10 remainder", 32'(remainder), 0);
   endtask

   task automatic t_integer();
      run_div(16'd1000, 16'd7, 1'b1, "R2 1000/7");
      run_div(16'd5, 16'd9, 1'b1, "R2 small/large");
      run_div(16'hFFFF, 16'd1, 1'b1, "R2 by one");
      run_div(16'hFFFF, 16'hFFFF, 1'b1, "R2 max/max");
      run_div(16'hABCD, 16'h0123, 1'b1, "R2 mixed");
   endtask

   task automatic t_fraction();
      run_div(16'd1, 16'd3, 1'b0, "R3 1/3");
      run_div(16'h7FFF, 16'hFFFF, 1'b0, "R3 near half");
      run_div(16'hFFFE, 16'hFFFF, 1'b0, "R3 just below one");
      run_div(16'd0, 16'd5, 1'b0, "R3 zero dividend");
   endtask

   task automatic t_overflow();
      run_div(16'h1234, 16'd0, 1'b1, "R5 int zero divisor");
      run_div(16'h00FF, 16'd0, 1'b0, "R5 frac zero divisor");
      run_div(16'd40, 16'd40, 1'b0, "R6 frac equal");
      run_div(16'd41, 16'd40, 1'b0, "R6 frac greater");
      run_div(16'd100, 16'd10, 1'b1, "R7 clear after overflow");
   endtask

   task automatic t_restart();
      start = 1'b1; dividend = 16'hFFFF; divisor = 16'd3; int_mode = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check("R8 busy mid-run", 32'(busy), 32'd1);
      run_div(16'd3, 16'd8, 1'b0, "R8 restart");
   endtask

   task automatic t_hold();
      logic [15:0] q0, r0;
      run_div(16'd777, 16'd10, 1'b1, "R9 setup");
      q0 = quotient; r0 = remainder;
      for (int i = 0; i < 8; i++) begin
         dividend = 16'(i * 4099); divisor = 16'(i); int_mode = i[0];
         @(negedge clk);
      end
      check("R9 quotient held", 32'(quotient), 32'(q0));
      check("R9 remainder held", 32'(remainder), 32'(r0));
      check("R9 overflow held", 32'(overflow), 32'd0);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_integer();
      t_fraction();
      t_overflow();
      t_restart();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule